// File: doc/BRIEF.md
# Hardware Blocking Semaphore Controller

This block holds a fixed set of synchronisation objects, each configurable as a mutex or as a counting semaphore, and shares them between threads running on a processor and threads built in logic. A thread acts on an object through a single bus access. The access address names the object, the thread and the operation, and the read data returns the outcome. The availability test, the state change and, when the resource is not available, the queuing of the thread id on that object's wait list all happen inside this one access. The bus holds the access until the block has finished, so the block handles one operation at a time and each operation is atomic.

Waiting threads are kept in first-in first-out order. Each object has its own wait list. All the lists are stored as linked chains in one next-pointer memory indexed by thread id. When a release finds a waiter, the block removes the oldest waiter from the list and gives it the resource. It then announces that thread id on a one-cycle notification port to the thread manager, which moves the thread from blocked to ready. The block does not talk to any scheduler directly.

Top module: `hsem_ctrl`

## Requirements
- R1: A request is taken at a rising edge while the block is idle. Address bits [1:0] give the operation (0 acquire, 1 release, 2 configure, 3 reserved), the next TID_W bits give the thread id, and the SEM_W bits above those give the object index. `bus_ack` goes high after the second rising edge from the one that took the request, which is well inside 8 cycles.
- R2: Acquiring an unlocked mutex locks it, records the caller as owner and returns status 0 (granted). Acquiring a mutex locked by another thread queues the caller and returns status 1 (blocked).
- R3: A release of a mutex that is unlocked, or that is owned by a different thread, returns status 2 (error) and leaves the mutex unchanged.
- R4: An owner's release with an empty wait list unlocks the mutex and returns status 3 (done). With waiters present, the oldest waiter becomes the owner, and `tm_valid` pulses with its id on `tm_tid` in the same cycle as `bus_ack`.
- R5: Waiters on one object are released strictly in the order in which they were blocked.
- R6: On a counting semaphore, an acquire with a nonzero count decrements it and returns 0. An acquire with a zero count queues the caller and returns 1. A release with no waiters increments the count and returns 3, or returns 2 with the count unchanged if the count is already at its maximum of 2^CNT_W-1.
- R7: A semaphore release with waiters leaves the count unchanged, grants the oldest waiter, returns 3 and notifies that waiter's id to the thread manager.
- R8: Configure sets the object type from `bus_wdata[CNT_W]` (1 mutex, 0 semaphore) and the count from `bus_wdata[CNT_W-1:0]`, leaves a mutex unlocked, and returns 3. If the object has waiters, configure returns 2 and changes nothing.
- R9: An acquire from a thread that is already queued, or from the current owner of that mutex, returns 2 and changes nothing.
- R10: The reserved operation returns 2 and changes nothing.
- R11: Every accepted request gets exactly one `bus_ack` pulse, one cycle long. `tm_valid` is high only in such a cycle. No new request is taken until the cycle after the acknowledge.
- R12: After reset every object is an unlocked mutex with an empty wait list, and `bus_ack` and `tm_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_addr | input | 2+TID_W+SEM_W | Object index, thread id and operation |
| bus_wdata | input | CNT_W+1 | Configure data: type bit and initial count |
| bus_ack | output | 1 | One-cycle completion strobe |
| bus_rdata | output | 2 | Status: 0 granted, 1 blocked, 2 error, 3 done |
| tm_valid | output | 1 | Thread-manager wake-up strobe |
| tm_tid | output | TID_W | Id of the thread being made ready |

## Verification
The bench runs a reference model alongside a long pseudo-random mix of acquire, release, configure and reserved operations over every object and thread. It also runs directed sequences for first-in first-out wake-up, count saturation, owner re-acquire and releases by a thread that does not own the mutex. A design that woke waiters last-in first-out, or that corrupted a chain when a list drained and refilled, would notify the wrong thread id. One that let a non-owner release would later grant a thread that should be blocked. One that let an already-queued thread acquire again would put the same thread on a list twice and lose a waiter. A held request is also checked to be served only once per three cycles, so a design that re-accepted a request during its own acknowledge would produce extra strobes.

// File: rtl/hsem_pkg.sv
package hsem_pkg;

    typedef enum logic [1:0] {
        OP_ACQ  = 2'd0,
        OP_REL  = 2'd1,
        OP_CFG  = 2'd2,
        OP_RSV  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RS_GRANT = 2'd0,
        RS_BLOCK = 2'd1,
        RS_ERR   = 2'd2,
        RS_DONE  = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_EXEC = 2'd1,
        FS_RESP = 2'd2
    } fsm_e;

endpackage

// File: rtl/hsem_addr_dec.sv
module hsem_addr_dec
    import hsem_pkg::*;
#(
    parameter int NUM_SEM = 4,
    parameter int TID_W   = 3,
    parameter int SEM_W   = 2,
    localparam int ADDR_W = 2 + TID_W + SEM_W
) (
    input  logic [ADDR_W-1:0] addr,
    output op_e               op,
    output logic [TID_W-1:0]  tid,
    output logic [SEM_W-1:0]  sem,
    output logic              sem_ok
);

    assign op     = op_e'(addr[1:0]);
    assign tid    = addr[2 +: TID_W];
    assign sem    = addr[2+TID_W +: SEM_W];
    assign sem_ok = (32'(sem) < NUM_SEM);

endmodule

// File: rtl/hsem_linkram.sv
module hsem_linkram #(
    parameter int NUM_THR = 8,
    parameter int TID_W   = 3
) (
    input  logic             clk,
    input  logic             we,
    input  logic [TID_W-1:0] waddr,
    input  logic [TID_W-1:0] wdata,
    input  logic [TID_W-1:0] raddr,
    output logic [TID_W-1:0] rdata
);

    logic [TID_W-1:0] nxt_mem [NUM_THR];

    always_ff @(posedge clk) begin
        if (we) begin
            nxt_mem[waddr] <= wdata;
        end
    end

    assign rdata = nxt_mem[raddr];

endmodule

// File: rtl/hsem_ctrl.sv
module hsem_ctrl
    import hsem_pkg::*;
#(
    parameter int NUM_SEM = 4,
    parameter int NUM_THR = 8,
    parameter int CNT_W   = 4,
    localparam int SEM_W  = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1,
    localparam int TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
    localparam int ADDR_W = 2 + TID_W + SEM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W:0]    bus_wdata,
    output logic              bus_ack,
    output logic [1:0]        bus_rdata,
    output logic              tm_valid,
    output logic [TID_W-1:0]  tm_tid
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             is_mutex;
        logic             locked;
        logic [TID_W-1:0] owner;
        logic [CNT_W-1:0] cnt;
        logic [TID_W-1:0] head;
        logic [TID_W-1:0] tail;
        logic [TID_W:0]   qlen;
    } entry_t;

    typedef struct packed {
        fsm_e             fsm;
        op_e              op;
        logic [SEM_W-1:0] sem;
        logic             sem_ok;
        logic [TID_W-1:0] tid;
        logic [CNT_W:0]   wd;
        logic             ack;
        rsp_e             rsp;
        logic             tmv;
        logic [TID_W-1:0] tmid;
    } ctl_t;

    localparam entry_t ENTRY_RST = '{is_mutex: 1'b1, default: '0};

    ctl_t               ctl_d, ctl_q;
    entry_t             tab_d [NUM_SEM];
    entry_t             tab_q [NUM_SEM];
    logic [NUM_THR-1:0] blk_d, blk_q;
    entry_t             cur_e;

    op_e                dec_op;
    logic [TID_W-1:0]   dec_tid;
    logic [SEM_W-1:0]   dec_sem;
    logic               dec_sem_ok;

    logic               lr_we;
    logic [TID_W-1:0]   lr_waddr, lr_wdata, lr_rdata;
    logic               do_enq, do_deq;

    hsem_addr_dec #(
        .NUM_SEM (NUM_SEM),
        .TID_W   (TID_W),
        .SEM_W   (SEM_W)
    ) u_dec (
        .addr    (bus_addr),
        .op      (dec_op),
        .tid     (dec_tid),
        .sem     (dec_sem),
        .sem_ok  (dec_sem_ok)
    );

    hsem_linkram #(
        .NUM_THR (NUM_THR),
        .TID_W   (TID_W)
    ) u_link (
        .clk     (clk),
        .we      (lr_we),
        .waddr   (lr_waddr),
        .wdata   (lr_wdata),
        .raddr   (cur_e.head),
        .rdata   (lr_rdata)
    );

    assign cur_e = ctl_q.sem_ok ? tab_q[ctl_q.sem] : ENTRY_RST;

    // Decide the operation outcome during FS_EXEC.
    always_comb begin
        ctl_d     = ctl_q;
        tab_d     = tab_q;
        blk_d     = blk_q;
        ctl_d.ack = 1'b0;
        ctl_d.tmv = 1'b0;
        do_enq    = 1'b0;
        do_deq    = 1'b0;
        lr_we     = 1'b0;
        lr_waddr  = cur_e.tail;
        lr_wdata  = ctl_q.tid;

        case (ctl_q.fsm)
            FS_IDLE: begin
                if (bus_req) begin
                    ctl_d.fsm    = FS_EXEC;
                    ctl_d.op     = dec_op;
                    ctl_d.tid    = dec_tid;
                    ctl_d.sem    = dec_sem;
                    ctl_d.sem_ok = dec_sem_ok;
                    ctl_d.wd     = bus_wdata;
                end
            end
            FS_EXEC: begin
                ctl_d.fsm = FS_RESP;
                ctl_d.ack = 1'b1;
                ctl_d.rsp = RS_ERR;
                if (ctl_q.sem_ok) begin
                    entry_t e;
                    e = cur_e;
                    case (ctl_q.op)
                        OP_ACQ: begin
                            if (blk_q[ctl_q.tid]) begin
                                ctl_d.rsp = RS_ERR;
                            end else if (e.is_mutex) begin
                                if (!e.locked) begin
                                    e.locked  = 1'b1;
                                    e.owner   = ctl_q.tid;
                                    ctl_d.rsp = RS_GRANT;
                                end else if (e.owner != ctl_q.tid) begin
                                    do_enq = 1'b1;
                                end
                            end else if (e.cnt != '0) begin
                                e.cnt     = e.cnt - 1'b1;
                                ctl_d.rsp = RS_GRANT;
                            end else begin
                                do_enq = 1'b1;
                            end
                        end
                        OP_REL: begin
                            if (e.is_mutex) begin
                                if (e.locked && (e.owner == ctl_q.tid)) begin
                                    ctl_d.rsp = RS_DONE;
                                    if (e.qlen != '0) begin
                                        do_deq  = 1'b1;
                                        e.owner = e.head;
                                    end else begin
                                        e.locked = 1'b0;
                                    end
                                end
                            end else if (e.qlen != '0) begin
                                do_deq    = 1'b1;
                                ctl_d.rsp = RS_DONE;
                            end else if (e.cnt != CNT_MAX) begin
                                e.cnt     = e.cnt + 1'b1;
                                ctl_d.rsp = RS_DONE;
                            end
                        end
                        OP_CFG: begin
                            if (e.qlen == '0) begin
                                e.is_mutex = ctl_q.wd[CNT_W];
                                e.cnt      = ctl_q.wd[CNT_W-1:0];
                                e.locked   = 1'b0;
                                e.owner    = '0;
                                ctl_d.rsp  = RS_DONE;
                            end
                        end
                        default: ctl_d.rsp = RS_ERR;
                    endcase

                    if (do_enq) begin
                        if (e.qlen == '0) begin
                            e.head = ctl_q.tid;
                        end else begin
                            lr_we = 1'b1;
                        end
                        e.tail              = ctl_q.tid;
                        e.qlen              = e.qlen + 1'b1;
                        blk_d[ctl_q.tid]    = 1'b1;
                        ctl_d.rsp           = RS_BLOCK;
                    end
                    if (do_deq) begin
                        ctl_d.tmv           = 1'b1;
                        ctl_d.tmid          = cur_e.head;
                        blk_d[cur_e.head]   = 1'b0;
                        e.head              = lr_rdata;
                        e.qlen              = e.qlen - 1'b1;
                    end
                    tab_d[ctl_q.sem] = e;
                end
            end
            default: begin
                ctl_d.fsm = FS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            blk_q <= '0;
            for (int i = 0; i < NUM_SEM; i++) begin
                tab_q[i] <= ENTRY_RST;
            end
        end else begin
            ctl_q <= ctl_d;
            blk_q <= blk_d;
            tab_q <= tab_d;
        end
    end

    assign bus_ack   = ctl_q.ack;
    assign bus_rdata = ctl_q.rsp;
    assign tm_valid  = ctl_q.tmv;
    assign tm_tid    = ctl_q.tmid;

    logic [1:0]       cur_op;
    logic [TID_W-1:0] cur_tid;
    assign cur_op  = ctl_q.op;
    assign cur_tid = ctl_q.tid;

endmodule

// File: rtl/hsem_checker.sv
module hsem_checker #(
    parameter int NUM_THR = 8,
    parameter int TID_W   = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_req,
    input logic               bus_ack,
    input logic [1:0]         bus_rdata,
    input logic               tm_valid,
    input logic [TID_W-1:0]   tm_tid,
    input logic [1:0]         cur_op,
    input logic [TID_W-1:0]   cur_tid,
    input logic [NUM_THR-1:0] blk_vec
);

    a_r11_ack_single: assert property (@(posedge clk) disable iff (rst)
        bus_ack |=> !bus_ack);

    a_r1_ack_after_req: assert property (@(posedge clk) disable iff (rst)
        bus_ack |-> ($past(bus_req) && $past(bus_req, 2)));

    a_r4_wake_on_release: assert property (@(posedge clk) disable iff (rst)
        tm_valid |-> (bus_ack && bus_rdata == 2'd3 && cur_op == 2'd1));

    a_r5_woken_not_queued: assert property (@(posedge clk) disable iff (rst)
        tm_valid |-> !blk_vec[tm_tid]);

    a_r2_block_marks_queue: assert property (@(posedge clk) disable iff (rst)
        (bus_ack && bus_rdata == 2'd1) |-> (blk_vec[cur_tid] && cur_op == 2'd0));

    a_r9_grant_not_queued: assert property (@(posedge clk) disable iff (rst)
        (bus_ack && bus_rdata == 2'd0) |-> !blk_vec[cur_tid]);

    a_r10_reserved_errors: assert property (@(posedge clk) disable iff (rst)
        (bus_ack && cur_op == 2'd3) |-> (bus_rdata == 2'd2 && !tm_valid));

endmodule

bind hsem_ctrl hsem_checker #(
    .NUM_THR (NUM_THR),
    .TID_W   (TID_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .tm_valid  (tm_valid),
    .tm_tid    (tm_tid),
    .cur_op    (cur_op),
    .cur_tid   (cur_tid),
    .blk_vec   (blk_q)
);

// File: tb/hsem_ctrl_bench.sv
`timescale 1ns/1ps
module hsem_ctrl_bench;

    localparam int NS     = 4;
    localparam int NT     = 8;
    localparam int CW     = 4;
    localparam int SW     = 2;
    localparam int TW     = 3;
    localparam int AW     = 2 + TW + SW;
    localparam int CMAX   = (1 << CW) - 1;
    localparam int C_GRANT = 0, C_BLOCK = 1, C_ERR = 2, C_DONE = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_req = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [CW:0]   bus_wdata = '0;
    logic          bus_ack;
    logic [1:0]    bus_rdata;
    logic          tm_valid;
    logic [TW-1:0] tm_tid;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    int m_mutex [NS];
    int m_cnt   [NS];
    int m_lock  [NS];
    int m_own   [NS];
    int m_qlen  [NS];
    int m_q     [NS][NT];
    int m_blk   [NT];

    always #4 clk = ~clk;

    hsem_ctrl u_hsem_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_req   (bus_req),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .tm_valid  (tm_valid),
        .tm_tid    (tm_tid)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    function automatic void m_enq(input int s, input int t);
        m_q[s][m_qlen[s]] = t;
        m_qlen[s]++;
        m_blk[t] = 1;
    endfunction

    function automatic int m_deq(input int s);
        int w = m_q[s][0];
        for (int i = 0; i < NT - 1; i++) m_q[s][i] = m_q[s][i+1];
        m_qlen[s]--;
        m_blk[w] = 0;
        return w;
    endfunction

    // Reference model: expected status, wake-up and requirement tag.
    task automatic model(input int op, input int s, input int t, input int wd,
                         output int est, output int etv, output int etid, output string tag);
        est = C_ERR; etv = 0; etid = 0; tag = "R10";
        if (op == 0) begin
            if (m_blk[t] != 0) begin tag = "R9"; end
            else if (m_mutex[s] != 0) begin
                tag = "R2";
                if (m_lock[s] == 0) begin m_lock[s] = 1; m_own[s] = t; est = C_GRANT; end
                else if (m_own[s] == t) tag = "R9";
                else begin m_enq(s, t); est = C_BLOCK; end
            end else begin
                tag = "R6";
                if (m_cnt[s] > 0) begin m_cnt[s]--; est = C_GRANT; end
                else begin m_enq(s, t); est = C_BLOCK; end
            end
        end else if (op == 1) begin
            if (m_mutex[s] != 0) begin
                if (m_lock[s] == 0 || m_own[s] != t) tag = "R3";
                else begin
                    tag = "R4"; est = C_DONE;
                    if (m_qlen[s] > 0) begin etid = m_deq(s); etv = 1; m_own[s] = etid; end
                    else m_lock[s] = 0;
                end
            end else if (m_qlen[s] > 0) begin
                tag = "R7"; est = C_DONE; etid = m_deq(s); etv = 1;
            end else begin
                tag = "R6";
                if (m_cnt[s] != CMAX) begin m_cnt[s]++; est = C_DONE; end
            end
        end else if (op == 2) begin
            tag = "R8";
            if (m_qlen[s] == 0) begin
                m_mutex[s] = (wd >> CW) & 1; m_cnt[s] = wd & CMAX;
                m_lock[s] = 0; m_own[s] = 0; est = C_DONE;
            end
        end
    endtask

    task automatic do_op(input int op, input int s, input int t, input int wd,
                         input string tag_over);
        int cyc = 0;
        int est, etv, etid, st, tv, tt;
        string tag;
        model(op, s, t, wd, est, etv, etid, tag);
        if (tag_over != "") tag = tag_over;
        bus_addr  = {s[SW-1:0], t[TW-1:0], op[1:0]};
        bus_wdata = wd[CW:0];
        bus_req   = 1'b1;
        do begin @(negedge clk); cyc++; end while (!bus_ack && cyc < 20);
        st = int'(bus_rdata); tv = int'(tm_valid); tt = int'(tm_tid);
        check(cyc == 2, "R1 ack latency", cyc, 2);
        check(st == est, tag, st, est);
        check(tv == etv, {tag, " wake strobe"}, tv, etv);
        if (etv != 0) check(tt == etid, {tag, " woken id"}, tt, etid);
        bus_req = 1'b0;
        @(negedge clk);
        check(!bus_ack && !tm_valid, "R11 single strobe", int'(bus_ack), 0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        int lfsr = 32'h1ACE_5EED;
        for (int i = 0; i < NS; i++) begin
            m_mutex[i] = 1; m_cnt[i] = 0; m_lock[i] = 0; m_own[i] = 0; m_qlen[i] = 0;
        end
        for (int i = 0; i < NT; i++) m_blk[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!bus_ack && !tm_valid, "R12 reset outputs", int'(bus_ack), 0);

        // R12: each object starts as an unlocked mutex.
        for (int s = 0; s < NS; s++) do_op(0, s, 0, 0, "R12");
        for (int s = 0; s < NS; s++) do_op(1, s, 0, 0, "R12");

        // R5: FIFO wake-up order on a mutex.
        do_op(0, 0, 1, 0, "");
        do_op(0, 0, 5, 0, "");
        do_op(0, 0, 2, 0, "");
        do_op(0, 0, 7, 0, "");
        do_op(0, 0, 7, 0, "R9");
        do_op(0, 0, 1, 0, "R9");
        do_op(1, 0, 2, 0, "R3");
        do_op(1, 0, 1, 0, "R5");
        do_op(1, 0, 5, 0, "R5");
        do_op(1, 0, 2, 0, "R5");
        do_op(1, 0, 7, 0, "R4");
        do_op(1, 0, 7, 0, "R3");

        // R8/R6/R7: semaphore count, saturation, waiter grant.
        do_op(2, 1, 0, (0 << CW) | 1, "R8");
        do_op(0, 1, 3, 0, "R6");
        do_op(0, 1, 4, 0, "R6");
        do_op(0, 1, 6, 0, "R6");
        do_op(2, 1, 0, 5, "R8");
        do_op(1, 1, 0, 0, "R7");
        do_op(1, 1, 0, 0, "R7");
        do_op(1, 1, 0, 0, "R6");
        do_op(2, 2, 0, CMAX - 1, "R8");
        do_op(1, 2, 3, 0, "R6");
        do_op(1, 2, 3, 0, "R6");
        do_op(3, 2, 3, 0, "R10");
        do_op(1, 2, 3, 0, "R10");

        // R11: held request is served once per three cycles.
        begin
            int acks = 0;
            int pos [2];
            int est, etv, etid;
            string tag;
            model(0, 2, 5, 0, est, etv, etid, tag);
            model(0, 2, 5, 0, est, etv, etid, tag);
            bus_addr = {2'd2, 3'd5, 2'd0};
            bus_req  = 1'b1;
            for (int c = 1; c <= 6; c++) begin
                @(negedge clk);
                if (bus_ack) begin
                    if (acks < 2) pos[acks] = c;
                    acks++;
                    check(bus_rdata == 2'd0, "R11 held grant", int'(bus_rdata), 0);
                end
            end
            bus_req = 1'b0;
            check(acks == 2, "R11 held ack count", acks, 2);
            check(pos[0] == 2 && pos[1] == 5, "R11 held ack spacing", pos[1], 5);
            @(negedge clk);
            @(negedge clk);
        end

        // Pseudo-random sweep against the model.
        for (int k = 0; k < 3000; k++) begin
            int r, op, s, t, wd;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            r  = lfsr;
            op = ((r & 15) < 7) ? 0 : (((r & 15) < 14) ? 1 : (((r & 15) == 14) ? 2 : 3));
            s  = (r >> 4) & 3;
            t  = (r >> 6) & 7;
            wd = (((r >> 9) & 1) << CW) | ((((r >> 10) & 1) != 0) ? (CMAX - 1) : ((r >> 11) & 3));
            do_op(op, s, t, wd, "");
        end

        finish_run();
    end

endmodule